// File: doc/BRIEF.md
# Single-Word Bus DMA Sequencer

This block moves 16-bit words between a local sector buffer and a host expansion bus. Each word needs its own bus cycle, and only one word moves per grant. Software, or a local controller, writes a request flag to start each word. The sequencer then asks the host arbiter for the bus and waits for a grant. It performs one data phase and clears the flag at the end of that phase. While the flag is clear, the previous word is known to be complete. A sector counter is loaded with the sector length. Each data phase decrements it and advances the buffer address. When it reaches zero, further requests are refused.

The transfer direction is chosen with `dir_to_host`. In the to-host direction the block drives the buffer word onto the bus and pulses the write strobe. In the from-host direction it pulses the read strobe and writes the bus word into the buffer. Two request policies are offered:
- Baseline: the next request waits until the host has ended the whole previous cycle by dropping the grant.
- Early: the next request is raised while the grant from the finished data phase is still high. Its data phase still waits for a fresh grant.

The burst line is tied inactive.

The controller has six states:
- IDLE: no request outstanding.
- ASK: bus request high, waiting for a grant.
- YIELD: request withdrawn while preempt is high.
- MOVE: the single data phase.
- TAIL: waiting for the grant to drop.
- PREASK: an early request raised before the grant has dropped.

The transitions are:
- IDLE→ASK when the flag is set and words remain.
- ASK→MOVE on a grant.
- ASK→YIELD when preempt is high and there is no grant.
- YIELD→ASK when preempt falls.
- MOVE→TAIL always.
- TAIL→IDLE when the grant drops.
- TAIL→PREASK in early mode, when the flag is set again while the grant is still high.
- PREASK→ASK when the grant drops.

Top module: `dma_word_seq`

## Requirements
- R1: After reset, `req_flag`, `bus_req`, `bus_rd`, `bus_wr`, `bus_oe` and `buf_we` are 0, `words_left` is 0 and `sector_done` is 1.
- R2: A `flag_set` pulse while `words_left` is 0 is ignored: `req_flag` stays 0 and no bus request appears.
- R3: A `sec_load` pulse sets `words_left` to SECTOR_WORDS (256 by default) and `buf_addr` to 0 at the next clock edge.
- R4: With the flag clear and no preempt, a `flag_set` pulse makes `bus_req` high two clock edges after the pulse is sampled. The first edge sets the flag and the second enters ASK.
- R5: In the to-host direction (`dir_to_host`=1), each grant yields exactly one cycle with `bus_wr`=1 and `bus_oe`=1, with `bus_dout` equal to the buffer word at `buf_addr`. After that cycle `req_flag` is 0, `words_left` is one less and `buf_addr` is one more.
- R6: In the from-host direction (`dir_to_host`=0), each grant yields exactly one cycle with `bus_rd`=1 and `buf_we`=1, with `buf_wdata` equal to `bus_din`.
- R7: `bus_oe`, `bus_rd` and `bus_wr` are high only while `bus_gnt` is high, `bus_oe` only together with `bus_wr`, and `bus_rd` and `bus_wr` are never high together.
- R8: `bus_burst` is always 0.
- R9: When `bus_preempt` is high before a grant, `bus_req` is withdrawn until preempt falls. Across preempt activity, every buffer word reaches the bus exactly once and in address order.
- R10: With `early_req_en`=0, `bus_req` stays low after a data phase until `bus_gnt` has dropped.
- R11: With `early_req_en`=1, a flag set after a data phase while `bus_gnt` is still high raises `bus_req` before the grant drops. The next data phase still waits for a new grant.
- R12: `sector_done` is 1 exactly when `words_left` is 0; it rises after the last word of a sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_load | input | 1 | Pulse: load sector length, address 0 |
| dir_to_host | input | 1 | 1 = buffer to bus, 0 = bus to buffer |
| early_req_en | input | 1 | 1 = early next request policy |
| flag_set | input | 1 | Pulse: set the transfer-request flag |
| req_flag | output | 1 | Transfer-request flag; 0 = last word done |
| sector_done | output | 1 | No words left in the sector |
| words_left | output | 9 | Words remaining in the sector |
| buf_addr | output | 8 | Buffer word address |
| buf_rdata | input | 16 | Buffer read data at `buf_addr` |
| buf_wdata | output | 16 | Buffer write data |
| buf_we | output | 1 | Buffer write enable |
| bus_req | output | 1 | DMA bus request |
| bus_gnt | input | 1 | Arbitration grant |
| bus_preempt | input | 1 | Another master wants the bus |
| bus_din | input | 16 | Data from the host bus |
| bus_dout | output | 16 | Data to the host bus |
| bus_oe | output | 1 | Data output enable |
| bus_rd | output | 1 | Read strobe (host to card) |
| bus_wr | output | 1 | Write strobe (card to host) |
| bus_burst | output | 1 | Burst request, held 0 |

## Verification
The bench pairs the block with a behavioural arbiter that waits a random number of cycles before granting. After each data phase it holds the grant for a random tail. It can also toggle preempt at random.

A full sector is sent in the to-host direction under baseline policy with preempt active. Comparing every captured bus word with the buffer, in order, exposes skipped words, duplicated words and stale data.

A shorter early-policy run, with no preempt, separates the two policies. A request seen during a grant tail must appear there and must never appear in the baseline run.

A from-host run with an incrementing bus pattern checks the write path. Pulses sent while no words are left check that refused requests leave no trace.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASK,
        ST_YIELD,
        ST_MOVE,
        ST_TAIL,
        ST_PREASK
    } seq_state_t;

endpackage

// File: rtl/dma_word_ctr.sv
module dma_word_ctr #(
    parameter int SECTOR_WORDS = 256,
    localparam int CNT_W = $clog2(SECTOR_WORDS + 1),
    localparam int AW    = $clog2(SECTOR_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    output logic [CNT_W-1:0] words_left,
    output logic [AW-1:0]    addr,
    output logic             empty
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_left <= '0;
            addr       <= '0;
        end else if (load) begin
            words_left <= CNT_W'(SECTOR_WORDS);
            addr       <= '0;
        end else if (step && (words_left != '0)) begin
            words_left <= words_left - 1'b1;
            addr       <= addr + 1'b1;
        end
    end

    assign empty = (words_left == '0);

endmodule

// File: rtl/dma_req_flag.sv
module dma_req_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic allow,
    input  logic clr,
    output logic flag
);

    // Completion clears the flag with priority over a new set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (clr) begin
            flag <= 1'b0;
        end else if (set_req && allow) begin
            flag <= 1'b1;
        end
    end

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    input  logic empty,
    input  logic early_en,
    input  logic dir_to_host,
    input  logic gnt,
    input  logic preempt,
    output logic move,
    output logic req,
    output logic rd,
    output logic wr,
    output logic oe,
    output logic we
);

    seq_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (flag && !empty) nxt = ST_ASK;
            end
            ST_ASK: begin
                if (gnt)          nxt = ST_MOVE;
                else if (preempt) nxt = ST_YIELD;
            end
            ST_YIELD: begin
                if (!preempt) nxt = ST_ASK;
            end
            ST_MOVE: begin
                nxt = ST_TAIL;
            end
            ST_TAIL: begin
                if (!gnt)                                   nxt = ST_IDLE;
                else if (early_en && flag && !empty)        nxt = ST_PREASK;
            end
            ST_PREASK: begin
                if (!gnt) nxt = ST_ASK;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        move = 1'b0;
        req  = 1'b0;
        rd   = 1'b0;
        wr   = 1'b0;
        oe   = 1'b0;
        we   = 1'b0;
        unique case (state)
            ST_ASK, ST_PREASK: req = 1'b1;
            ST_MOVE: begin
                move = 1'b1;
                wr   = dir_to_host;
                oe   = dir_to_host;
                rd   = !dir_to_host;
                we   = !dir_to_host;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_word_seq.sv
module dma_word_seq #(
    parameter int SECTOR_WORDS = 256,
    parameter int DATA_W       = 16,
    localparam int CNT_W = $clog2(SECTOR_WORDS + 1),
    localparam int AW    = $clog2(SECTOR_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_load,
    input  logic              dir_to_host,
    input  logic              early_req_en,
    input  logic              flag_set,
    output logic              req_flag,
    output logic              sector_done,
    output logic [CNT_W-1:0]  words_left,
    output logic [AW-1:0]     buf_addr,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic [DATA_W-1:0] buf_wdata,
    output logic              buf_we,
    output logic              bus_req,
    input  logic              bus_gnt,
    input  logic              bus_preempt,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_burst
);

    logic move;
    logic empty;

    dma_word_ctr #(.SECTOR_WORDS(SECTOR_WORDS)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (sec_load),
        .step       (move),
        .words_left (words_left),
        .addr       (buf_addr),
        .empty      (empty)
    );

    dma_req_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (flag_set),
        .allow   (!empty),
        .clr     (move),
        .flag    (req_flag)
    );

    dma_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .flag        (req_flag),
        .empty       (empty),
        .early_en    (early_req_en),
        .dir_to_host (dir_to_host),
        .gnt         (bus_gnt),
        .preempt     (bus_preempt),
        .move        (move),
        .req         (bus_req),
        .rd          (bus_rd),
        .wr          (bus_wr),
        .oe          (bus_oe),
        .we          (buf_we)
    );

    assign sector_done = empty;
    assign buf_wdata   = bus_din;
    assign bus_dout    = bus_oe ? buf_rdata : '0;
    assign bus_burst   = 1'b0;

endmodule

// File: rtl/dma_word_seq_chk.sv
module dma_word_seq_chk #(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sec_load,
    input logic             early_req_en,
    input logic             flag_set,
    input logic             req_flag,
    input logic             sector_done,
    input logic [CNT_W-1:0] words_left,
    input logic             bus_req,
    input logic             bus_gnt,
    input logic             bus_oe,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic             bus_burst
);

    assert_strobe_in_gnt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe || bus_rd || bus_wr) |-> bus_gnt);

    assert_rd_wr_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    assert_oe_with_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> bus_wr);

    assert_burst_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_burst);

    assert_one_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |=> !(bus_rd || bus_wr));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && !sec_load) |=> (words_left == $past(words_left) - 1'b1) && !req_flag);

    assert_no_early_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!early_req_en && (bus_rd || bus_wr)) |=> !bus_req);

    assert_refused_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set && sector_done && !req_flag) |=> !req_flag);

    assert_done_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sector_done == (words_left == '0));

endmodule

bind dma_word_seq dma_word_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sec_load     (sec_load),
    .early_req_en (early_req_en),
    .flag_set     (flag_set),
    .req_flag     (req_flag),
    .sector_done  (sector_done),
    .words_left   (words_left),
    .bus_req      (bus_req),
    .bus_gnt      (bus_gnt),
    .bus_oe       (bus_oe),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_burst    (bus_burst)
);

// File: tb/tb_dma_word_seq.sv
`timescale 1ns/1ps
module tb_dma_word_seq;

    localparam int SW = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_load = 1'b0;
    logic        dir_to_host = 1'b1;
    logic        early_req_en = 1'b0;
    logic        flag_set = 1'b0;
    logic        req_flag, sector_done;
    logic [8:0]  words_left;
    logic [7:0]  buf_addr;
    logic [15:0] buf_rdata, buf_wdata, bus_din, bus_dout;
    logic        buf_we, bus_req, bus_oe, bus_rd, bus_wr, bus_burst;
    logic        bus_gnt = 1'b0;
    logic        bus_preempt = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [15:0] mem [SW];
    logic [15:0] cap [SW];
    int cap_n = 0;
    int rd_seen = 0;
    int early_seen = 0;
    int viol_r7 = 0;
    int viol_r8 = 0;
    bit post_phase = 0;
    bit pre_en = 0;
    int wait_cnt = 0;
    int tail = 0;

    always #10 clk = ~clk;

    dma_word_seq dut (
        .clk(clk), .rst_n(rst_n), .sec_load(sec_load), .dir_to_host(dir_to_host),
        .early_req_en(early_req_en), .flag_set(flag_set), .req_flag(req_flag),
        .sector_done(sector_done), .words_left(words_left), .buf_addr(buf_addr),
        .buf_rdata(buf_rdata), .buf_wdata(buf_wdata), .buf_we(buf_we),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_preempt(bus_preempt),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_burst(bus_burst)
    );

    assign buf_rdata = mem[buf_addr];
    assign bus_din   = 16'hC000 + 16'(rd_seen);

    always @(posedge clk) begin
        if (buf_we) mem[buf_addr] <= buf_wdata;
        if (bus_rd) rd_seen <= rd_seen + 1;
    end

    // Behavioural arbiter: random grant delay, random tail, optional preempt.
    always @(posedge clk) begin
        bus_preempt <= pre_en && (($urandom % 4) == 0);
        if (!rst_n) begin
            bus_gnt  <= 1'b0;
            wait_cnt <= 0;
            tail     <= 0;
        end else if (!bus_gnt) begin
            if (bus_req && !bus_preempt) begin
                if (wait_cnt == 0) bus_gnt <= 1'b1;
                else wait_cnt <= wait_cnt - 1;
            end else if (!bus_req) begin
                wait_cnt <= int'($urandom % 4);
            end
        end else begin
            if (bus_rd || bus_wr) tail <= 3 + int'($urandom % 3);
            else if (tail == 1) begin bus_gnt <= 1'b0; tail <= 0; wait_cnt <= int'($urandom % 4); end
            else if (tail > 1) tail <= tail - 1;
        end
    end

    // Port monitor sampled between edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_wr && cap_n < SW) begin cap[cap_n] = bus_dout; cap_n = cap_n + 1; end
            if ((bus_oe || bus_rd || bus_wr) && !bus_gnt) viol_r7 = viol_r7 + 1;
            if (bus_rd && bus_wr) viol_r7 = viol_r7 + 1;
            if (bus_oe && !bus_wr) viol_r7 = viol_r7 + 1;
            if (bus_burst) viol_r8 = viol_r8 + 1;
            if (bus_rd || bus_wr) post_phase = 1;
            else if (!bus_gnt) post_phase = 0;
            else if (post_phase && bus_req) early_seen = early_seen + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_sector();
        @(negedge clk) sec_load = 1'b1;
        @(negedge clk) sec_load = 1'b0;
        cap_n = 0;
    endtask

    // Send n words, one flag write each; flag re-set as soon as it reads clear.
    task automatic run_words(input int n);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            flag_set = 1'b1;
            @(negedge clk) flag_set = 1'b0;
            for (int t = 0; t < 400 && req_flag; t++) @(negedge clk);
        end
        for (int t = 0; t < 20 && bus_gnt; t++) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 req_flag", req_flag, 0);
        check("R1 bus_req", bus_req, 0);
        check("R1 strobes", {bus_rd, bus_wr, bus_oe, buf_we}, 0);
        check("R1 words_left", words_left, 0);
        check("R12 done at reset", sector_done, 1);
    endtask

    task automatic t_refused(input string tag);
        @(negedge clk) flag_set = 1'b1;
        @(negedge clk) flag_set = 1'b0;
        @(negedge clk);
        check({tag, " flag stays clear"}, req_flag, 0);
        check({tag, " no request"}, bus_req, 0);
    endtask

    task automatic t_load();
        load_sector();
        check("R3 words_left", words_left, SW);
        check("R3 buf_addr", buf_addr, 0);
        check("R12 not done", sector_done, 0);
    endtask

    task automatic t_latency_first_word();
        @(negedge clk) flag_set = 1'b1;
        @(negedge clk) flag_set = 1'b0;
        check("R4 flag set", req_flag, 1);
        check("R4 req not yet", bus_req, 0);
        @(negedge clk);
        check("R4 req raised", bus_req, 1);
        for (int t = 0; t < 100 && req_flag; t++) @(negedge clk);
        check("R5 flag cleared", req_flag, 0);
        check("R5 words_left step", words_left, SW - 1);
        check("R5 addr step", buf_addr, 1);
        check("R5 one word", cap_n, 1);
        for (int t = 0; t < 20 && bus_gnt; t++) @(negedge clk);
    endtask

    task automatic t_full_sector_preempt();
        int errs = 0;
        pre_en = 1;
        early_seen = 0;
        run_words(SW - 1);
        pre_en = 0;
        check("R9 word count", cap_n, SW);
        for (int k = 0; k < SW; k++) if (cap[k] !== mem[k]) errs++;
        check("R9 order and content", errs, 0);
        check("R10 no early request", early_seen, 0);
        check("R12 done after sector", sector_done, 1);
        check("R12 words_left zero", words_left, 0);
    endtask

    task automatic t_early();
        int errs = 0;
        early_req_en = 1'b1;
        load_sector();
        early_seen = 0;
        run_words(40);
        early_req_en = 1'b0;
        check("R11 early request seen", early_seen > 0, 1);
        check("R11 word count", cap_n, 40);
        for (int k = 0; k < 40; k++) if (cap[k] !== mem[k]) errs++;
        check("R11 order and content", errs, 0);
    endtask

    task automatic t_from_host();
        int errs = 0;
        dir_to_host = 1'b0;
        load_sector();
        rd_seen = 0;
        run_words(20);
        check("R6 read strobes", rd_seen, 20);
        check("R6 no write strobes", cap_n, 0);
        for (int k = 0; k < 20; k++) if (mem[k] !== 16'(16'hC000 + k)) errs++;
        check("R6 buffer content", errs, 0);
        check("R6 buffer beyond untouched", mem[20], 16'(20 * 16'h1357) ^ 16'h5A5A);
        dir_to_host = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < SW; i++) mem[i] = 16'(i * 16'h1357) ^ 16'h5A5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_refused("R2 empty sector");
        t_load();
        t_latency_first_word();
        t_full_sector_preempt();
        t_refused("R2 after sector end");
        t_early();
        t_from_host();
        check("R7 strobe/grant violations", viol_r7, 0);
        check("R8 burst never high", viol_r8, 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule